// File: doc/BRIEF.md
# Feature State Query Master

This block is a bus master that asks a shared 64-bit register mailbox whether a given feature is disabled or locked. A one-cycle request carries a 9-bit feature number. The block first waits until nobody owns the mailbox and then writes the query command. Next it waits until the mailbox grants ownership to this side and starts the command with the run-busy bit and a packet length. It then waits for run-busy to drop and checks the result code. On success it reads back the reply word. Whatever happened after the command was started, it releases the mailbox with a completion write. The caller receives a one-cycle `done` pulse together with an error code and the two feature flags.

Each of the three waits is a poll loop with two limits. After a status read that does not match, the block pauses for `INTERVAL_CYCLES` and then reads again. Once `LIMIT_CYCLES` have passed since the phase began, a read that still does not match ends the wait with a timeout. One shared timer serves all three phases and is restarted at the start of each phase.

State machine: `S_IDLE` moves to `S_POLL_RD` on a request. `S_POLL_RD` moves to `S_POLL_WAIT` when the read is accepted. `S_POLL_WAIT` moves on when the response arrives:
- if the condition matches, to `S_CMD_WR` (after the free-owner poll), to `S_RUN_WR` (after the in-band-owner poll), or to `S_DAT_RD` or `S_CPL_WR` (after the run-busy poll);
- if the condition does not match and the limit is hit, to `S_DONE` (owner polls) or to `S_CPL_WR` (run-busy poll);
- otherwise to `S_POLL_GAP`.

`S_POLL_GAP` returns to `S_POLL_RD` when the pause ends. `S_CMD_WR` and `S_RUN_WR` go back to `S_POLL_RD` when their write is accepted, and each starts a new phase. `S_DAT_RD` goes to `S_DAT_WAIT`, which goes to `S_CPL_WR`. `S_CPL_WR` goes to `S_DONE`, and `S_DONE` returns to `S_IDLE` after one cycle.

Top module: `feature_query_master`

## Requirements
- R1: Before any write, the status word at offset 0x00 is polled until its owner field (bits 5:4) reads 0. The command word is then written at offset 0x08 with opcode 0x10 in bits 7:0, the feature number in bits 48:40 and all other bits zero.
- R2: After the command write, status is polled until the owner field reads 1. The value 0x0000_0000_0002_0001 is then written at offset 0x00: run-busy in bit 0 and packet length 2 in bits 31:16.
- R3: After the run write, status is polled until bit 0 reads 0. If the result code in bits 15:8 is not 0x40, the block reports error 3 and never reads offset 0x08.
- R4: On result 0x40, offset 0x08 is read exactly once. `disabled` is 1 when bit 32 of that word is 0, `locked` equals bit 63, and the error is 0.
- R5: The write 0x40 (completion, bit 6) to offset 0x00 is the last write after success, after a bad result and after a run-busy timeout. No completion write is issued when an owner poll times out.
- R6: After a status read that does not match, the next status read comes at least `INTERVAL_CYCLES` later. A non-matching read arriving once `LIMIT_CYCLES` have passed in a phase ends the poll: with error 1 in either owner phase, or with error 2 in the run-busy phase.
- R7: A request that arrives while a query is in progress is ignored. It causes no bus access and no extra `done`.
- R8: `done` is high for exactly one cycle per accepted request. Error codes are 0 none, 1 owner timeout, 2 run-busy timeout and 3 bad result. `locked` and `disabled` are 0 whenever the error is not 0.
- R9: A bus request holds its address, direction and data until `bus_ready`. A write completes on that handshake. A read completes on `bus_rsp_valid`, and no new access starts while a read is outstanding.
- R10: After reset, `done` and `bus_valid` are low until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle query request |
| req_feature | input | 9 | Feature number for the query |
| done | output | 1 | One-cycle end-of-query pulse |
| err | output | 2 | Error code, valid with `done` |
| locked | output | 1 | Feature is locked, valid with `done` |
| disabled | output | 1 | Feature is disabled, valid with `done` |
| bus_valid | output | 1 | Bus access request |
| bus_ready | input | 1 | Bus accepts the request |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Byte offset in the mailbox |
| bus_wdata | output | 64 | Write data |
| bus_rsp_valid | input | 1 | Read data strobe |
| bus_rsp_rdata | input | 64 | Read data |

## Verification
The bench builds the block with `INTERVAL_CYCLES` = 3 and `LIMIT_CYCLES` = 30. With these values, every timeout path ends within a few dozen cycles, so both owner-phase timeouts and the run-busy timeout are exercised next to the success and bad-result paths. The short pause also makes the number of status reads in a timed-out phase small and easy to bound. `bus_ready` drops one cycle in three, so requests are held through stalls.

// File: rtl/fq_pkg.sv
package fq_pkg;
    localparam int WORD_W = 64;
    localparam int FEAT_W = 9;
    localparam logic [7:0]  OP_GET_STATE = 8'h10;
    localparam logic [7:0]  RESULT_OK    = 8'h40;
    localparam logic [15:0] PKT_LEN      = 16'd2;

    typedef enum logic [1:0] {
        ERR_NONE       = 2'd0,
        ERR_OWNER_TO   = 2'd1,
        ERR_RUN_TO     = 2'd2,
        ERR_BAD_RESULT = 2'd3
    } fq_err_e;

    typedef enum logic [1:0] {
        PH_FREE,
        PH_INBAND,
        PH_RUN
    } fq_phase_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_POLL_RD,
        S_POLL_WAIT,
        S_POLL_GAP,
        S_CMD_WR,
        S_RUN_WR,
        S_DAT_RD,
        S_DAT_WAIT,
        S_CPL_WR,
        S_DONE
    } fq_state_e;

    typedef struct packed {
        logic       run_busy;
        logic [1:0] owner;
        logic [7:0] result;
    } fq_status_t;
endpackage

// File: rtl/fq_poll_timer.sv
module fq_poll_timer #(
    parameter int INTERVAL_CYCLES = 1_000_000,
    parameter int LIMIT_CYCLES    = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic gap_start,
    output logic gap_done,
    output logic limit_hit
);
    localparam int LIM_W = $clog2(LIMIT_CYCLES + 1);
    localparam int GAP_W = $clog2(INTERVAL_CYCLES + 1);
    localparam logic [LIM_W-1:0] LIM_MAX  = LIM_W'(LIMIT_CYCLES);
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(INTERVAL_CYCLES);

    logic [LIM_W-1:0] elapsed;
    logic [GAP_W-1:0] gap_left;

    // Phase age saturates at the limit; pause counter runs down to zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed  <= '0;
            gap_left <= '0;
        end else begin
            if (restart)
                elapsed <= '0;
            else if (elapsed != LIM_MAX)
                elapsed <= elapsed + LIM_W'(1);

            if (gap_start)
                gap_left <= GAP_LOAD;
            else if (gap_left != '0)
                gap_left <= gap_left - GAP_W'(1);
        end
    end

    assign limit_hit = (elapsed == LIM_MAX);
    assign gap_done  = (gap_left == '0);
endmodule

// File: rtl/fq_status_decode.sv
module fq_status_decode
    import fq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fq_status_t        status,
    output logic              feat_locked,
    output logic              feat_disabled
);
    logic unused_bits;

    assign status.run_busy = word[0];
    assign status.owner    = word[5:4];
    assign status.result   = word[15:8];

    // Reply payload lives in the upper half of the data word.
    assign feat_locked   = word[63];
    assign feat_disabled = ~word[32];

    assign unused_bits = ^{word[62:33], word[31:16], word[7:6], word[3:1]};
endmodule

// File: rtl/feature_query_master.sv
module feature_query_master
    import fq_pkg::*;
#(
    parameter int ADDR_W          = 4,
    parameter int INTERVAL_CYCLES = 1_000_000,
    parameter int LIMIT_CYCLES    = 100_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [8:0]        req_feature,
    output logic              done,
    output logic [1:0]        err,
    output logic              locked,
    output logic              disabled,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [63:0]       bus_wdata,
    input  logic              bus_rsp_valid,
    input  logic [63:0]       bus_rsp_rdata
);
    localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(8);

    fq_state_e         state_q, state_d;
    fq_phase_e         phase_q;
    fq_err_e           err_q;
    logic [FEAT_W-1:0] feat_q;
    logic              locked_q, disabled_q;

    logic              restart, gap_start, gap_done, limit_hit;
    fq_status_t        stat;
    logic              rsp_locked, rsp_disabled;
    logic              poll_met;
    logic [WORD_W-1:0] cmd_word, run_word, cpl_word;

    fq_poll_timer #(
        .INTERVAL_CYCLES(INTERVAL_CYCLES),
        .LIMIT_CYCLES   (LIMIT_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .gap_start(gap_start),
        .gap_done (gap_done),
        .limit_hit(limit_hit)
    );

    fq_status_decode u_decode (
        .word         (bus_rsp_rdata),
        .status       (stat),
        .feat_locked  (rsp_locked),
        .feat_disabled(rsp_disabled)
    );

    always_comb begin
        cmd_word        = '0;
        cmd_word[7:0]   = OP_GET_STATE;
        cmd_word[48:40] = feat_q;
        run_word        = '0;
        run_word[0]     = 1'b1;
        run_word[31:16] = PKT_LEN;
        cpl_word        = '0;
        cpl_word[6]     = 1'b1;
    end

    always_comb begin
        unique case (phase_q)
            PH_FREE:   poll_met = (stat.owner == 2'd0);
            PH_INBAND: poll_met = (stat.owner == 2'd1);
            PH_RUN:    poll_met = ~stat.run_busy;
            default:   poll_met = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and bus outputs
    always_comb begin
        state_d   = state_q;
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr  = CTRL_OFS;
        bus_wdata = '0;
        restart   = 1'b0;
        gap_start = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    restart = 1'b1;
                    state_d = S_POLL_RD;
                end
            end
            S_POLL_RD: begin
                bus_valid = 1'b1;
                if (bus_ready) state_d = S_POLL_WAIT;
            end
            S_POLL_WAIT: begin
                if (bus_rsp_valid) begin
                    if (poll_met) begin
                        unique case (phase_q)
                            PH_FREE:   state_d = S_CMD_WR;
                            PH_INBAND: state_d = S_RUN_WR;
                            default:   state_d = (stat.result == RESULT_OK) ? S_DAT_RD : S_CPL_WR;
                        endcase
                    end else if (limit_hit) begin
                        state_d = (phase_q == PH_RUN) ? S_CPL_WR : S_DONE;
                    end else begin
                        gap_start = 1'b1;
                        state_d   = S_POLL_GAP;
                    end
                end
            end
            S_POLL_GAP: begin
                if (gap_done) state_d = S_POLL_RD;
            end
            S_CMD_WR: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = DATA_OFS;
                bus_wdata = cmd_word;
                if (bus_ready) begin
                    restart = 1'b1;
                    state_d = S_POLL_RD;
                end
            end
            S_RUN_WR: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_wdata = run_word;
                if (bus_ready) begin
                    restart = 1'b1;
                    state_d = S_POLL_RD;
                end
            end
            S_DAT_RD: begin
                bus_valid = 1'b1;
                bus_addr  = DATA_OFS;
                if (bus_ready) state_d = S_DAT_WAIT;
            end
            S_DAT_WAIT: begin
                if (bus_rsp_valid) state_d = S_CPL_WR;
            end
            S_CPL_WR: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_wdata = cpl_word;
                if (bus_ready) state_d = S_DONE;
            end
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Query context and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            feat_q     <= '0;
            phase_q    <= PH_FREE;
            err_q      <= ERR_NONE;
            locked_q   <= 1'b0;
            disabled_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        feat_q     <= req_feature;
                        phase_q    <= PH_FREE;
                        err_q      <= ERR_NONE;
                        locked_q   <= 1'b0;
                        disabled_q <= 1'b0;
                    end
                end
                S_CMD_WR: if (bus_ready) phase_q <= PH_INBAND;
                S_RUN_WR: if (bus_ready) phase_q <= PH_RUN;
                S_POLL_WAIT: begin
                    if (bus_rsp_valid) begin
                        if (poll_met) begin
                            if (phase_q == PH_RUN && stat.result != RESULT_OK)
                                err_q <= ERR_BAD_RESULT;
                        end else if (limit_hit) begin
                            err_q <= (phase_q == PH_RUN) ? ERR_RUN_TO : ERR_OWNER_TO;
                        end
                    end
                end
                S_DAT_WAIT: begin
                    if (bus_rsp_valid) begin
                        locked_q   <= rsp_locked;
                        disabled_q <= rsp_disabled;
                    end
                end
                default: ;
            endcase
        end
    end

    assign done     = (state_q == S_DONE);
    assign err      = err_q;
    assign locked   = locked_q;
    assign disabled = disabled_q;
endmodule

// File: rtl/fq_checker.sv
module fq_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic [1:0]        err,
    input logic              locked,
    input logic              disabled,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [63:0]       bus_wdata,
    input logic              bus_rsp_valid
);
    logic rd_open;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   rd_open <= 1'b0;
        else if (bus_valid && bus_ready && !bus_write) rd_open <= 1'b1;
        else if (bus_rsp_valid)                        rd_open <= 1'b0;
    end

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_clears_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err != 2'd0) |-> (!locked && !disabled));

    assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)
                                       && $stable(bus_write) && $stable(bus_wdata)));

    assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !rd_open);

    assert_rsp_expected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rsp_valid |-> rd_open);

    assert_cpl_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == ADDR_W'(0) && bus_wdata[6])
            |-> (bus_wdata == 64'h40));

    assert_cmd_opcode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == ADDR_W'(8)) |-> (bus_wdata[7:0] == 8'h10));
endmodule

bind feature_query_master fq_checker #(.ADDR_W(ADDR_W)) u_fq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .done         (done),
    .err          (err),
    .locked       (locked),
    .disabled     (disabled),
    .bus_valid    (bus_valid),
    .bus_ready    (bus_ready),
    .bus_write    (bus_write),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rsp_valid(bus_rsp_valid)
);

// File: tb/feature_query_master_bench.sv
module feature_query_master_bench;
    localparam int AW  = 4;
    localparam int GAP = 3;
    localparam int LIM = 30;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [8:0]  req_feature = '0;
    logic        done;
    logic [1:0]  err;
    logic        locked, disabled;
    logic        bus_valid, bus_ready, bus_write;
    logic [AW-1:0] bus_addr;
    logic [63:0] bus_wdata;
    logic        bus_rsp_valid = 1'b0;
    logic [63:0] bus_rsp_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int done_cnt = 0;

    logic [67:0] exp_wr[$];
    logic [3:0]  exp_res[$];

    // Mailbox model configuration (driven by the driver only)
    logic        cfg_load = 1'b0;
    int          cfg_busy = 0;
    logic        cfg_free_ok = 1'b1, cfg_inband_ok = 1'b1, cfg_rb_clear = 1'b1;
    int          cfg_rb_reads = 0;
    logic [7:0]  cfg_result = 8'h40;
    logic [31:0] cfg_val = '0;

    // Mailbox model state
    int cyc = 0, busy_left = 0, rb_left = 0, mphase = 0;
    int data_reads = 0, stat_reads = 0;

    assign bus_ready = (cyc % 3) != 2;

    feature_query_master #(
        .ADDR_W(AW), .INTERVAL_CYCLES(GAP), .LIMIT_CYCLES(LIM)
    ) u_feature_query_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_feature(req_feature),
        .done(done), .err(err), .locked(locked), .disabled(disabled),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rsp_valid(bus_rsp_valid), .bus_rsp_rdata(bus_rsp_rdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [67:0] act, input logic [67:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] status_word();
        logic [1:0] own;
        logic       rb;
        if (mphase == 0)      own = (busy_left > 0 || !cfg_free_ok) ? 2'd2 : 2'd0;
        else if (mphase == 1) own = cfg_inband_ok ? 2'd1 : 2'd0;
        else                  own = 2'd1;
        rb = (mphase == 2) && (rb_left > 0 || !cfg_rb_clear);
        return {32'h0, 16'h0, cfg_result, 2'b00, own, 3'b000, rb};
    endfunction

    // Mailbox responder
    always @(posedge clk) begin
        cyc <= cyc + 1;
        bus_rsp_valid <= 1'b0;
        if (cfg_load) begin
            mphase    <= 0;
            busy_left <= cfg_busy;
        end else if (rst_n && bus_valid && bus_ready) begin
            if (bus_write) begin
                if (bus_addr == 4'h8) mphase <= 1;
                else if (bus_wdata[0]) begin
                    mphase  <= 2;
                    rb_left <= cfg_rb_reads;
                end
            end else begin
                bus_rsp_valid <= 1'b1;
                if (bus_addr == 4'h0) begin
                    stat_reads    <= stat_reads + 1;
                    bus_rsp_rdata <= status_word();
                    if (mphase == 0 && busy_left > 0) busy_left <= busy_left - 1;
                    if (mphase == 2 && rb_left > 0)   rb_left   <= rb_left - 1;
                end else begin
                    data_reads    <= data_reads + 1;
                    bus_rsp_rdata <= {cfg_val, 32'h0000_0010};
                end
            end
        end
    end

    // Monitor: compares bus writes and results against the scoreboard
    always @(negedge clk) begin
        if (rst_n && bus_valid && bus_ready) begin
            if (bus_write) begin
                if (exp_wr.size() == 0)
                    check(1'b0, "R1,R2,R5,R7", "unexpected write", {bus_addr, bus_wdata}, '0);
                else begin
                    logic [67:0] e;
                    e = exp_wr.pop_front();
                    check({bus_addr, bus_wdata} == e, "R1,R2,R5,R9", "write", {bus_addr, bus_wdata}, e);
                end
            end else begin
                check(!bus_rsp_valid, "R9", "read while read open", 68'(bus_rsp_valid), 68'd0);
            end
        end
        if (rst_n && done) begin
            done_cnt++;
            if (exp_res.size() == 0)
                check(1'b0, "R7,R8", "unexpected done", 68'({err, locked, disabled}), '0);
            else begin
                logic [3:0] r;
                r = exp_res.pop_front();
                check({err, locked, disabled} == r, "R3,R4,R6,R8", "result {err,locked,disabled}",
                      68'({err, locked, disabled}), 68'(r));
            end
        end
    end

    task automatic run_query(input logic [8:0] feat, input int busy, input bit free_ok,
                             input bit inband_ok, input bit rb_clear, input int rb_reads,
                             input logic [7:0] res, input logic [31:0] val, input bit stray,
                             output int lat, output int nstat);
        int d0, r0, t0, s0, guard;
        logic [1:0] e;
        cfg_busy = busy; cfg_free_ok = free_ok; cfg_inband_ok = inband_ok;
        cfg_rb_clear = rb_clear; cfg_rb_reads = rb_reads; cfg_result = res; cfg_val = val;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        if (free_ok) exp_wr.push_back({4'h8, 64'h10 | (64'(feat) << 40)});
        if (free_ok && inband_ok) begin
            exp_wr.push_back({4'h0, 64'h0000_0000_0002_0001});
            exp_wr.push_back({4'h0, 64'h40});
        end
        e = (!free_ok || !inband_ok) ? 2'd1 : !rb_clear ? 2'd2 : (res != 8'h40) ? 2'd3 : 2'd0;
        exp_res.push_back({e, (e == 2'd0) && val[31], (e == 2'd0) && !val[0]});
        d0 = done_cnt; r0 = data_reads; t0 = cyc; s0 = stat_reads;
        req_feature = feat; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (stray) begin
            repeat (4) @(negedge clk);
            req_feature = ~feat; req_valid = 1'b1;   // R7: must be ignored
            @(negedge clk);
            req_valid = 1'b0;
        end
        guard = 0;
        while (done_cnt == d0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        lat   = cyc - t0;
        nstat = stat_reads - s0;
        check(done_cnt == d0 + 1, "R8", "done count", 68'(done_cnt - d0), 68'd1);
        check(data_reads - r0 == ((e == 2'd0) ? 1 : 0), "R3,R4", "data word reads",
              68'(data_reads - r0), 68'((e == 2'd0) ? 1 : 0));
        repeat (40) @(negedge clk);
        check(done_cnt == d0 + 1, "R7", "no extra done", 68'(done_cnt - d0), 68'd1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int lat, ns;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R10", "done in reset", 68'(done), 68'd0);
        check(bus_valid == 1'b0, "R10", "bus_valid in reset", 68'(bus_valid), 68'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(bus_valid == 1'b0 && done == 1'b0, "R10", "idle after reset",
              68'({bus_valid, done}), 68'd0);

        // Success, owner busy for two reads, run-busy for two reads
        run_query(9'h1A5, 2, 1, 1, 1, 2, 8'h40, 32'h0000_0001, 0, lat, ns);
        // Success with locked and disabled, plus a stray request while busy
        run_query(9'h003, 0, 1, 1, 1, 0, 8'h40, 32'h8000_0000, 1, lat, ns);
        // Bad result code
        run_query(9'h1FF, 1, 1, 1, 1, 1, 8'h41, 32'h0000_0001, 0, lat, ns);
        // Run-busy never clears
        run_query(9'h055, 0, 1, 1, 0, 0, 8'h40, 32'h0000_0001, 0, lat, ns);
        check(lat >= LIM, "R6", "run-busy timeout latency lower bound", 68'(lat), 68'(LIM));
        // Owner never frees
        run_query(9'h0AA, 0, 0, 1, 1, 0, 8'h40, 32'h0000_0001, 0, lat, ns);
        check(lat >= LIM && lat <= LIM + GAP + 12, "R6", "owner timeout latency", 68'(lat), 68'(LIM));
        check(ns >= 2 && ns <= LIM / GAP + 2, "R6", "status reads in timed-out phase",
              68'(ns), 68'(LIM / GAP));
        // Owner never grants in-band
        run_query(9'h100, 0, 1, 0, 1, 0, 8'h40, 32'h0000_0001, 0, lat, ns);
        check(lat >= LIM, "R6", "in-band timeout latency", 68'(lat), 68'(LIM));
        // Success, locked but enabled
        run_query(9'h100, 3, 1, 1, 1, 3, 8'h40, 32'h8000_0001, 1, lat, ns);

        check(exp_wr.size() == 0, "R5", "writes left unseen", 68'(exp_wr.size()), 68'd0);
        check(exp_res.size() == 0, "R8", "results left unseen", 68'(exp_res.size()), 68'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule